// File: doc/BRIEF.md
# Converter Power-Up Sequencer

This block supervises the start-up and recovery of a DC-DC converter. It is evaluated only on a slow periodic tick (nominally one pulse every 100 µs). It walks the converter through six phases: waiting for sensor calibration, input precharge, controller setup, a reference ramp, steady regulation, and a fault hold. Operator commands arrive as single-cycle strobes and are kept until the next tick. A new output-voltage target arrives over a valid/ready stream input.

The sequencer drives the voltage reference seen by the outer control loop. On a tick in the ramp phase the reference moves toward the target by a programmable step, and it always ends exactly on the target. A target change during regulation does not alter the reference at once: it sends the machine back into the ramp phase. A fault seen at a tick forces the fault phase and drops the reference to zero. A fault reset is only honoured once the fault condition has gone.

Setpoint stream rules: a word is taken on a clock edge where `sp_valid` and `sp_ready` are both high. The taken word becomes the target at the next tick. `sp_ready` stays low from the edge that takes a word until that tick. A word offered while `sp_ready` is low is not taken, and the sender must hold it.

Top module: `psu_sequencer`

## Requirements
- R1: After reset the state is 0 (calibration wait), `vref` is 0, `loop_en` and `handover` are low and `sp_ready` is high.
- R2: State codes are 0 calibration wait, 1 precharge, 2 standby, 3 ramp, 4 regulate, 5 fault. The state and `vref` change only on a clock edge where `tick` is high.
- R3: In state 0, a tick with `cal_done` high moves to state 1. Without `cal_done` the state stays 0.
- R4: In state 1, a start-power strobe is ignored until a start-precharge strobe has been taken at an earlier tick. After that, a start-power strobe moves the machine to state 2.
- R5: State 2 lasts one tick and then moves to state 3. `loop_en` is high in states 2, 3 and 4. `handover` is high in states 3 and 4 only.
- R6: On each tick in state 3 where `vref` differs from the target, `vref` moves toward the target by `ramp_step`, up or down, and is clamped to the target so that it never overshoots. A step of 0 acts as a step of 1.
- R7: A tick in state 3 with `vref` equal to the target moves the machine to state 4.
- R8: A tick in state 4 with the target different from `vref` moves the machine to state 3, with `vref` unchanged at that tick.
- R9: A tick with `fault_active` high moves the machine from any state to state 5 and sets `vref` to 0. `vref` is 0 throughout state 5.
- R10: In state 5, a fault-reset strobe at a tick with `fault_active` low moves the machine to state 1, where a new start-precharge strobe is required. With `fault_active` high the machine stays in state 5.
- R11: A setpoint word taken on the stream becomes the target at the next tick. `sp_ready` is low from the edge that takes a word until that tick, and words offered meanwhile are ignored.
- R12: A command strobe is kept until the next tick and is then discarded, whether or not it was used. A strobe that has no effect in the current state does not carry over into the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle evaluation pulse |
| cal_done | input | 1 | Sensor offset calibration finished |
| start_pre | input | 1 | Start-precharge command strobe |
| start_pwr | input | 1 | Start-power-transfer command strobe |
| fault_reset | input | 1 | Fault-reset command strobe |
| fault_active | input | 1 | Fault condition present (level) |
| ramp_step | input | REF_W | Reference change per tick in ramp phase |
| sp_valid | input | 1 | Setpoint word offered |
| sp_ready | output | 1 | Setpoint word can be taken |
| sp_data | input | REF_W | Setpoint word |
| state | output | 3 | Current state code |
| loop_en | output | 1 | Control loops enabled |
| handover | output | 1 | Switches and rectifiers under loop control |
| vref | output | REF_W | Ramped voltage reference |

## Verification
The bench ramps up in steps that do not divide the target, then down, and finally with a zero step. A design that overshoots would leave `vref` above or below the target. One that treats a zero step as zero would never reach regulation. The bench sends start-power before any precharge command, both at first entry and again after a fault recovery. A design that keeps a stale precharge flag or stale strobes would jump to standby too early. It also issues a fault reset while the fault persists, which a careless design would wrongly accept. It offers a second setpoint while the first is pending, which a design without back-pressure would let overwrite the target.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;
  typedef enum logic [2:0] {
    ST_CALWAIT = 3'd0,
    ST_PRECHG  = 3'd1,
    ST_STANDBY = 3'd2,
    ST_RAMP    = 3'd3,
    ST_REGUL   = 3'd4,
    ST_FAULT   = 3'd5
  } seq_state_e;

  localparam int unsigned CMD_N   = 3;
  localparam int unsigned CMD_PRE = 0;
  localparam int unsigned CMD_PWR = 1;
  localparam int unsigned CMD_RST = 2;
endpackage

// File: rtl/seq_cmd_latch.sv
module seq_cmd_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] cmd
);
  logic [N-1:0] held;

  for (genvar g = 0; g < N; g++) begin : g_cmd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held[g] <= 1'b0;
      else if (tick)  held[g] <= 1'b0;
      else            held[g] <= held[g] | strobe[g];
    end
    // a strobe in the tick cycle itself counts for that tick
    assign cmd[g] = held[g] | strobe[g];
  end
endmodule

// File: rtl/seq_setpoint.sv
module seq_setpoint #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         sp_valid,
  input  logic [W-1:0] sp_data,
  output logic         sp_ready,
  output logic [W-1:0] target
);
  logic         pend_vld;
  logic [W-1:0] pend_val;

  assign sp_ready = !pend_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_val <= '0;
      target   <= '0;
    end else begin
      if (tick && pend_vld) begin
        target   <= pend_val;
        pend_vld <= 1'b0;
      end
      if (sp_valid && sp_ready) begin
        pend_val <= sp_data;
        pend_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_ramp.sv
module seq_ramp #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         clear,
  input  logic [W-1:0] step,
  input  logic [W-1:0] target,
  output logic [W-1:0] vref,
  output logic         at_target
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         going_up;
  logic [W-1:0] gap;
  logic [W-1:0] eff_step;
  logic [W-1:0] ref_nxt;

  assign at_target = (vref == target);
  assign going_up  = (target > vref);
  assign gap       = going_up ? (target - vref) : (vref - target);
  assign eff_step  = (step == '0) ? ONE : step;

  always_comb begin
    if (gap <= eff_step)  ref_nxt = target;
    else if (going_up)    ref_nxt = vref + eff_step;
    else                  ref_nxt = vref - eff_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vref <= '0;
    else if (clear)    vref <= '0;
    else if (step_en)  vref <= ref_nxt;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import psu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cal_done,
  input  logic       fault_active,
  input  logic       cmd_pre,
  input  logic       cmd_pwr,
  input  logic       cmd_rst,
  input  logic       at_target,
  output seq_state_e cur,
  output logic       step_en,
  output logic       clear,
  output logic       loop_en,
  output logic       handover
);
  seq_state_e nxt;
  logic       pre_done;

  always_comb begin
    nxt     = cur;
    step_en = 1'b0;
    clear   = 1'b0;
    if (tick) begin
      if (fault_active) begin
        nxt   = ST_FAULT;
        clear = 1'b1;
      end else begin
        unique case (cur)
          ST_CALWAIT: if (cal_done) nxt = ST_PRECHG;
          ST_PRECHG:  if (pre_done && cmd_pwr) nxt = ST_STANDBY;
          ST_STANDBY: nxt = ST_RAMP;
          ST_RAMP: begin
            if (at_target) nxt = ST_REGUL;
            else           step_en = 1'b1;
          end
          ST_REGUL:   if (!at_target) nxt = ST_RAMP;
          ST_FAULT:   if (cmd_rst) nxt = ST_PRECHG;
          default:    nxt = ST_FAULT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= ST_CALWAIT;
      pre_done <= 1'b0;
    end else if (tick) begin
      cur <= nxt;
      if (nxt == ST_PRECHG && cur != ST_PRECHG) pre_done <= 1'b0;
      else if (cur == ST_PRECHG && cmd_pre)     pre_done <= 1'b1;
    end
  end

  assign loop_en  = (cur == ST_STANDBY) || (cur == ST_RAMP) || (cur == ST_REGUL);
  assign handover = (cur == ST_RAMP) || (cur == ST_REGUL);
endmodule

// File: rtl/psu_sequencer.sv
module psu_sequencer
  import psu_seq_pkg::*;
#(
  parameter int unsigned REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cal_done,
  input  logic             start_pre,
  input  logic             start_pwr,
  input  logic             fault_reset,
  input  logic             fault_active,
  input  logic [REF_W-1:0] ramp_step,
  input  logic             sp_valid,
  output logic             sp_ready,
  input  logic [REF_W-1:0] sp_data,
  output logic [2:0]       state,
  output logic             loop_en,
  output logic             handover,
  output logic [REF_W-1:0] vref
);
  logic [CMD_N-1:0] strobes;
  logic [CMD_N-1:0] cmds;
  logic [REF_W-1:0] target;
  logic             at_target;
  logic             step_en;
  logic             clear;
  seq_state_e       cur;

  assign strobes[CMD_PRE] = start_pre;
  assign strobes[CMD_PWR] = start_pwr;
  assign strobes[CMD_RST] = fault_reset;

  seq_cmd_latch #(.N(CMD_N)) u_cmd (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(strobes), .cmd(cmds)
  );

  seq_setpoint #(.W(REF_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sp_valid(sp_valid),
    .sp_data(sp_data), .sp_ready(sp_ready), .target(target)
  );

  seq_ramp #(.W(REF_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .clear(clear),
    .step(ramp_step), .target(target), .vref(vref), .at_target(at_target)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_done(cal_done),
    .fault_active(fault_active), .cmd_pre(cmds[CMD_PRE]),
    .cmd_pwr(cmds[CMD_PWR]), .cmd_rst(cmds[CMD_RST]),
    .at_target(at_target), .cur(cur), .step_en(step_en), .clear(clear),
    .loop_en(loop_en), .handover(handover)
  );

  assign state = cur;
endmodule

// File: rtl/psu_seq_chk.sv
module psu_seq_chk #(
  parameter int unsigned REF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             fault_active,
  input logic             sp_ready,
  input logic [2:0]       state,
  input logic             loop_en,
  input logic             handover,
  input logic [REF_W-1:0] vref
);
  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5);
  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));
  // R2
  vref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(vref));
  // R9
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && fault_active |=> state == 3'd5);
  // R9
  fault_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd5 |-> vref == '0);
  // R5
  handover_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handover |-> loop_en);
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_ready && !tick |=> !sp_ready);
endmodule

bind psu_sequencer psu_seq_chk #(.REF_W(REF_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fault_active(fault_active),
  .sp_ready(sp_ready), .state(state), .loop_en(loop_en),
  .handover(handover), .vref(vref)
);

// File: tb/test_psu_sequencer.sv
module test_psu_sequencer;
  localparam int unsigned W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         cal_done = 1'b0;
  logic         start_pre = 1'b0;
  logic         start_pwr = 1'b0;
  logic         fault_reset = 1'b0;
  logic         fault_active = 1'b0;
  logic [W-1:0] ramp_step = '0;
  logic         sp_valid = 1'b0;
  logic         sp_ready;
  logic [W-1:0] sp_data = '0;
  logic [2:0]   state;
  logic         loop_en;
  logic         handover;
  logic [W-1:0] vref;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psu_sequencer #(.REF_W(W)) i_psu_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_done(cal_done),
    .start_pre(start_pre), .start_pwr(start_pwr), .fault_reset(fault_reset),
    .fault_active(fault_active), .ramp_step(ramp_step), .sp_valid(sp_valid),
    .sp_ready(sp_ready), .sp_data(sp_data), .state(state), .loop_en(loop_en),
    .handover(handover), .vref(vref)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: start_pre = 1'b1;
      1: start_pwr = 1'b1;
      default: fault_reset = 1'b1;
    endcase
    @(negedge clk);
    start_pre = 1'b0; start_pwr = 1'b0; fault_reset = 1'b0;
  endtask

  task automatic send_sp(input int val);
    @(negedge clk);
    check("R11 ready before offer", sp_ready, 1);
    sp_valid = 1'b1; sp_data = W'(val);
    @(negedge clk);
    sp_valid = 1'b0;
    check("R11 ready low while pending", sp_ready, 0);
  endtask

  // ramp model: one tick in the ramp phase
  function automatic int model_step(input int r, input int t, input int s);
    int e;
    e = (s == 0) ? 1 : s;
    if (t > r) return (t - r <= e) ? t : r + e;
    return (r - t <= e) ? t : r - e;
  endfunction

  task automatic ramp_to(input int start, input int tgt, input int stp);
    int r;
    r = start;
    while (r != tgt) begin
      r = model_step(r, tgt, stp);
      do_tick();
      check("R6 ramp value", vref, r);
      check("R6 still ramping", state, 3);
    end
    do_tick();
    check("R7 enter regulation", state, 4);
    check("R7 vref held", vref, tgt);
  endtask

  task automatic t_reset();
    check("R1 state", state, 0);
    check("R1 vref", vref, 0);
    check("R1 loop_en", loop_en, 0);
    check("R1 handover", handover, 0);
    check("R1 sp_ready", sp_ready, 1);
  endtask

  task automatic t_calwait();
    do_tick();
    check("R3 stay without cal_done", state, 0);
    pulse(0);
    cal_done = 1'b1;
    do_tick();
    check("R3 to precharge", state, 1);
    repeat (5) @(negedge clk);
    check("R2 no change without tick", state, 1);
  endtask

  task automatic t_precharge();
    pulse(1);
    do_tick();
    check("R4 start-power before precharge ignored", state, 1);
    do_tick();
    check("R12 stale strobe dropped", state, 1);
    send_sp(100);
    @(negedge clk) sp_valid = 1'b1; sp_data = W'(999);
    @(negedge clk) sp_valid = 1'b0;
    pulse(0);
    do_tick();
    check("R4 precharge taken", state, 1);
    check("R11 ready after tick", sp_ready, 1);
    pulse(1);
    do_tick();
    check("R4 to standby", state, 2);
    check("R5 loop_en standby", loop_en, 1);
    check("R5 no handover standby", handover, 0);
    check("R2 vref unchanged standby", vref, 0);
    do_tick();
    check("R5 to ramp", state, 3);
    check("R5 handover ramp", handover, 1);
    check("R5 vref not yet stepped", vref, 0);
  endtask

  task automatic t_ramp_up();
    ramp_step = W'(30);
    ramp_to(0, 100, 30);
    check("R5 handover regulate", handover, 1);
  endtask

  task automatic t_change(input int from, input int tgt, input int stp);
    ramp_step = W'(stp);
    send_sp(tgt);
    do_tick();
    check("R8 regulate until target applied", state, 4);
    do_tick();
    check("R8 back to ramp", state, 3);
    check("R8 vref unchanged", vref, from);
    ramp_to(from, tgt, stp);
  endtask

  task automatic t_fault();
    fault_active = 1'b1;
    do_tick();
    check("R9 fault state", state, 5);
    check("R9 vref zero", vref, 0);
    check("R9 loop_en off", loop_en, 0);
    pulse(2);
    do_tick();
    check("R10 reset refused while fault", state, 5);
    fault_active = 1'b0;
    do_tick();
    check("R10 no reset stays", state, 5);
    pulse(2);
    do_tick();
    check("R10 to precharge", state, 1);
    pulse(1);
    do_tick();
    check("R10 precharge needed again", state, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_calwait();
    t_precharge();
    t_ramp_up();
    t_change(100, 40, 30);
    t_change(40, 42, 0);
    t_fault();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule